// File: doc/BRIEF.md
# Polyphase Fractional Rate Resampler

This block changes the sample rate of a real sample stream by the rational factor L/M. In concept, the stream is zero-stuffed by L, low-pass filtered at the high rate, and then only every M-th high-rate sample is kept. The block does not run that high-rate filter. It computes only the kept outputs, and for each one it applies the single polyphase branch (coefficient subset) that produces it. The filter arithmetic therefore runs at the output rate and not at L times the input rate.

A phase register advances by M for every output produced and wraps modulo L. Each wrap consumes one new input sample, so a step spanning several wraps consumes several inputs before the next output. The prototype filter has L·T taps and is held in an internal coefficient ROM. Phase p uses the taps at prototype positions p, p+L, p+2L, and so on, applied to a history of the T most recent inputs. L and M are static settings, changed only while reset is held.

The producer presents samples with a one-cycle valid strobe. The consumer receives a one-cycle valid strobe with each output.

Top module: `polyphase_resampler`

## Requirements
- R1: Output number j (counting from 0 after reset) equals Σ_{t=0..T-1} h[p + L·t] · x[i − t], where i = floor(j·M/L) and p = j·M mod L. This matches zero-stuffing by L, filtering with h, and keeping every M-th sample.
- R2: The prototype coefficients are h[n] = ((5·n + 3) mod 11) − 5 for n = 0 .. MAX_L·T − 1. ROM row p holds the taps at positions p + L·t, and tap t multiplies the input t samples older than the newest one.
- R3: The phase advances by M for each output and wraps modulo L. Each wrap consumes exactly one input, and a step covering k wraps consumes k inputs before the next output, even when M > L.
- R4: While in_valid is low and the block is waiting for input, the phase and the history hold. Idle gaps of any length between samples leave the output sequence unchanged.
- R5: An output is emitted only once its newest input has index ≥ T−1. Outputs that would reach back before the first sample are dropped, and out_valid stays low until T inputs have arrived.
- R6: rst_n is an asynchronous active-low reset. It clears the history, sets the phase to zero, and forces out_valid and out_data to 0.
- R7: Every sample whose valid strobe comes at least ceil(L/M) cycles after the previous one is consumed exactly once and in order. Back-to-back strobes are accepted when L ≤ M, and at most one output is produced per clock.
- R8: After N inputs and enough idle cycles, the number of outputs equals the number of j with T−1 ≤ floor(j·M/L) ≤ N−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_l | input | $clog2(MAX_L+1) | Interpolation factor L, 1..MAX_L, static |
| cfg_m | input | $clog2(MAX_M+1) | Decimation factor M, 1..MAX_M, static |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW+CW+$clog2(T) | Signed output sample |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- **Wrap counting when M exceeds L.** Ratios such as 1/3 and 2/3 need several inputs per output. A controller that consumed only one input per wrap would pair the wrong history with each phase, and every value would drift.
- **Phase selection when L exceeds M.** Ratios such as 4/1 and 8/5 depend on the correct phase, and a wrong ROM row index shows up as wrong coefficients on outputs that sit between inputs.
- **Warm-up suppression.** Feeding T−1 samples must give silence, and the T-th sample must give exactly one value. A design that emitted early would add leading outputs built on zeros.
- **Long idle gaps.** These show whether a design loses or repeats phase state while stalled.
- **Reset in the middle of a stream.** Leftover history would corrupt the first outputs after reset.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  // Prototype low-pass coefficient as a function of prototype tap index.
  function automatic int proto_coef(input int n);
    return ((5 * n + 3) % 11) - 5;
  endfunction

  // Outputs per consumed input, rounded up: minimum input strobe spacing.
  function automatic int min_spacing(input int l, input int m);
    return (l + m - 1) / m;
  endfunction

endpackage

// File: rtl/rsmp_phase_ctrl.sv
module rsmp_phase_ctrl #(
  parameter int AW = 5,
  parameter int LW = 4,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_l,
  input  logic [MW-1:0] cfg_m,
  input  logic          in_valid,
  input  logic          hist_empty,
  input  logic          hist_full,
  output logic          take,
  output logic          emit,
  output logic [AW-1:0] phase
);

  logic [AW-1:0] acc_q, acc_d, acc_step;
  logic          starve, slot, acc_en;
  logic [AW-1:0] l_ext, m_ext;

  assign l_ext = AW'(cfg_l);
  assign m_ext = AW'(cfg_m);

  // Next-state logic
  always_comb begin
    starve   = hist_empty || (acc_q >= l_ext);
    slot     = !starve;
    acc_step = slot ? (acc_q + m_ext) : acc_q;
    take     = in_valid && (starve || (acc_step >= l_ext));
    acc_d    = (take && !hist_empty) ? (acc_step - l_ext) : acc_step;
    emit     = slot && hist_full;
    acc_en   = slot || take;
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign phase = acc_q;

endmodule

// File: rtl/rsmp_history.sv
module rsmp_history #(
  parameter int DW   = 16,
  parameter int TAPS = 4,
  parameter int FW   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic [DW-1:0]             in_data,
  output logic [TAPS-1:0][DW-1:0]   hist,
  output logic [FW-1:0]             fill,
  output logic                      empty,
  output logic                      full
);

  logic [TAPS-1:0][DW-1:0] hist_q, hist_d;
  logic [FW-1:0]           fill_q, fill_d;

  // Next-state logic: newest sample lands in slot 0
  always_comb begin
    hist_d    = hist_q;
    hist_d[0] = in_data;
    for (int t = 1; t < TAPS; t++) begin
      hist_d[t] = hist_q[t-1];
    end
    fill_d = (fill_q == FW'(TAPS)) ? fill_q : (fill_q + FW'(1));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (take) begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  assign hist  = hist_q;
  assign fill  = fill_q;
  assign empty = (fill_q == '0);
  assign full  = (fill_q == FW'(TAPS));

endmodule

// File: rtl/rsmp_coef_rom.sv
module rsmp_coef_rom #(
  parameter int CW    = 8,
  parameter int TAPS  = 4,
  parameter int MAX_L = 8,
  parameter int AW    = 5,
  parameter int LW    = 4
) (
  input  logic [AW-1:0]            phase,
  input  logic [LW-1:0]            cfg_l,
  output logic [TAPS-1:0][CW-1:0]  coefs
);

  localparam int ROM_DEPTH = MAX_L * TAPS;
  localparam int IW        = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  logic [CW-1:0] rom [ROM_DEPTH];

  // Prototype taps computed once per entry
  for (genvar n = 0; n < ROM_DEPTH; n++) begin : g_rom
    assign rom[n] = CW'(rsmp_pkg::proto_coef(n));
  end

  // Row of phase p: prototype taps p, p+L, p+2L, ...
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      int idx;
      idx = int'(phase) + int'(cfg_l) * t;
      if (idx < ROM_DEPTH) begin
        coefs[t] = rom[idx[IW-1:0]];
      end else begin
        coefs[t] = '0;
      end
    end
  end

endmodule

// File: rtl/rsmp_mac.sv
module rsmp_mac #(
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int TAPS = 4,
  parameter int OW   = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     emit,
  input  logic [TAPS-1:0][DW-1:0]  hist,
  input  logic [TAPS-1:0][CW-1:0]  coefs,
  output logic                     out_valid,
  output logic [OW-1:0]            out_data
);

  logic signed [OW-1:0] sum;
  logic                 vld_q;
  logic [OW-1:0]        dat_q;

  // Dot product of history with the selected phase row
  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++) begin
      sum = sum + (OW'($signed(hist[t])) * OW'($signed(coefs[t])));
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (emit) begin
      dat_q <= sum;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/polyphase_resampler.sv
module polyphase_resampler #(
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int TAPS  = 4,
  parameter int MAX_L = 8,
  parameter int MAX_M = 8,
  localparam int LW   = $clog2(MAX_L + 1),
  localparam int MW   = $clog2(MAX_M + 1),
  localparam int OW   = DW + CW + $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_l,
  input  logic [MW-1:0] cfg_m,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  localparam int AW = $clog2(MAX_L + MAX_M + 1);
  localparam int FW = $clog2(TAPS + 1);

  logic                     take, emit, hist_empty, hist_full;
  logic [AW-1:0]            acc_q;
  logic [FW-1:0]            fill_cnt;
  logic [TAPS-1:0][DW-1:0]  hist;
  logic [TAPS-1:0][CW-1:0]  coefs;

  rsmp_phase_ctrl #(.AW(AW), .LW(LW), .MW(MW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_l(cfg_l), .cfg_m(cfg_m),
    .in_valid(in_valid), .hist_empty(hist_empty), .hist_full(hist_full),
    .take(take), .emit(emit), .phase(acc_q)
  );

  rsmp_history #(.DW(DW), .TAPS(TAPS), .FW(FW)) hist_i (
    .clk(clk), .rst_n(rst_n), .take(take), .in_data(in_data),
    .hist(hist), .fill(fill_cnt), .empty(hist_empty), .full(hist_full)
  );

  rsmp_coef_rom #(.CW(CW), .TAPS(TAPS), .MAX_L(MAX_L), .AW(AW), .LW(LW)) rom_i (
    .phase(acc_q), .cfg_l(cfg_l), .coefs(coefs)
  );

  rsmp_mac #(.DW(DW), .CW(CW), .TAPS(TAPS), .OW(OW)) mac_i (
    .clk(clk), .rst_n(rst_n), .emit(emit), .hist(hist), .coefs(coefs),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/rsmp_chk.sv
module rsmp_chk #(
  parameter int TAPS = 4,
  parameter int AW   = 5,
  parameter int FW   = 3,
  parameter int LW   = 4,
  parameter int MW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] cfg_l,
  input logic [MW-1:0] cfg_m,
  input logic          in_valid,
  input logic          out_valid,
  input logic [AW-1:0] acc,
  input logic [FW-1:0] fill
);

  // R6
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      reset_quiet_chk: assert (!out_valid);
    end
  end

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc) < int'(cfg_l) + int'(cfg_m));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && (fill == '0 || int'(acc) >= int'(cfg_l))) |=> $stable(acc));

  // R4
  no_phantom_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != $past(fill)) |-> $past(in_valid));

  // R5
  warm_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(fill) == FW'(TAPS)));

endmodule

bind polyphase_resampler rsmp_chk #(
  .TAPS(TAPS), .AW(AW), .FW(FW), .LW(LW), .MW(MW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_l(cfg_l), .cfg_m(cfg_m),
  .in_valid(in_valid), .out_valid(out_valid), .acc(acc_q), .fill(fill_cnt)
);

// File: tb/polyphase_resampler_tb_top.sv
module polyphase_resampler_tb_top;

  localparam int DW    = 16;
  localparam int CW    = 8;
  localparam int TAPS  = 4;
  localparam int MAX_L = 8;
  localparam int MAX_M = 8;
  localparam int LW    = $clog2(MAX_L + 1);
  localparam int MW    = $clog2(MAX_M + 1);
  localparam int OW    = DW + CW + $clog2(TAPS);
  localparam int CAP   = 256;

  // {L, M, extra idle cycles, sample count}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][4] = '{
    '{3, 2, 0, 24}, '{2, 3, 0, 24}, '{4, 1, 0, 20}, '{1, 3, 0, 30},
    '{5, 5, 0, 16}, '{3, 2, 3, 20}, '{7, 3, 1, 18}, '{8, 5, 0, 20}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] cfg_l = LW'(1);
  logic [MW-1:0] cfg_m = MW'(1);
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int got [CAP];
  int got_n = 0;

  always #2 clk = ~clk;

  polyphase_resampler #(.DW(DW), .CW(CW), .TAPS(TAPS), .MAX_L(MAX_L), .MAX_M(MAX_M)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_l(cfg_l), .cfg_m(cfg_m),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got_n < CAP) got[got_n] = int'($signed(out_data));
      got_n = got_n + 1;
    end
  end

  function automatic int hval(int n);
    return ((5 * n + 3) % 11) - 5;
  endfunction

  function automatic int xval(int seed, int n);
    return ((n * 97 + seed * 131 + 7) % 401) - 200;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int l, int m);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    cfg_l    = LW'(l);
    cfg_m    = MW'(m);
    repeat (3) @(negedge clk);
    got_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic feed(int seed, int first, int count, int gap);
    for (int n = first; n < first + count; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(xval(seed, n));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int model(int seed, int l, int m, int j);
    int i, p, s;
    i = (j * m) / l;
    p = (j * m) % l;
    s = 0;
    for (int t = 0; t < TAPS; t++) s += hval(p + l * t) * xval(seed, i - t);
    return s;
  endfunction

  task automatic run_stream(int seed, int l, int m, int extra, int nsamp, string sreq);
    int k;
    do_reset(l, m);
    feed(seed, 0, nsamp, (l + m - 1) / m - 1 + extra);
    repeat (3 * l + 10) @(negedge clk);
    k = 0;
    for (int j = 0; (j * m) / l <= nsamp - 1; j++) begin
      if ((j * m) / l >= TAPS - 1) begin
        // R1 R2 R3: value and order of each kept output
        if (k < got_n && k < CAP)
          check(got[k] == model(seed, l, m, j), "R1", got[k], model(seed, l, m, j));
        k++;
      end
    end
    // R8: output count; R4 or R7 by stimulus spacing
    check(got_n == k, "R8", got_n, k);
    check(got_n == k, sreq, got_n, k);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int e;
    // R6: reset state
    do_reset(3, 2);
    check(out_valid == 1'b0, "R6", int'(out_valid), 0);
    check(out_data == '0, "R6", int'(out_data), 0);

    // Table of ratios, walked in one loop
    for (int v = 0; v < NVEC; v++) begin
      run_stream(v, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                 (VEC[v][2] > 0) ? "R4" : "R7");
    end

    // R5: T-1 samples give silence, the T-th gives exactly one output
    do_reset(1, 1);
    feed(99, 0, TAPS - 1, 0);
    repeat (6) @(negedge clk);
    check(got_n == 0, "R5", got_n, 0);
    feed(99, TAPS - 1, 1, 0);
    repeat (4) @(negedge clk);
    check(got_n == 1, "R5", got_n, 1);
    e = model(99, 1, 1, TAPS - 1);
    check(got[0] == e, "R5", got[0], e);

    // R6: reset mid-stream clears history and phase
    do_reset(4, 1);
    feed(55, 0, 6, 3);
    run_stream(12, 3, 2, 0, 16, "R6");

    // R3: long decimation step consuming several inputs per output
    run_stream(21, 1, 7, 0, 40, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule